// File: doc/BRIEF.md
# Crosswise 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their full 8-bit product with no clock and no state. It works column by column. Column k gathers every AND term whose operand indices add up to k. It adds those terms to the carries arriving from the column below, using a fixed network of explicit half-adder and full-adder cells.

The network has eight half adders and seven full adders. Columns 3 and 4 can produce sums of up to six. For that reason a column may send more than one carry bit upward, and each of those bits is routed to the next column. The block is intended as the leaf cell of wider hierarchical multipliers. Its output is taken directly from the adder network.

Top module: `cross_mul4`

## Requirements
- R1: Output bit r[0] equals a[0] AND b[0] for every operand pair.
- R2: For all 256 operand pairs, r equals the unsigned product of a and b, with a and b read as plain binary numbers where bit 0 is the least significant bit.
- R3: When either operand is zero, r is 8'h00.
- R4: When one operand is 4'd1, r equals the other operand zero-extended to 8 bits.
- R5: Exchanging a and b leaves r unchanged.
- R6: r never exceeds 8'd225, and the pair a = b = 4'hF gives exactly 8'hE1.
- R7: Output bit r[1] equals (a[1] AND b[0]) XOR (a[0] AND b[1]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First unsigned operand |
| b | input | 4 | Second unsigned operand |
| r | output | 8 | Unsigned product a times b |

## Verification
The columns at risk are 3 and 4, where the sum reaches six and two carry bits leave the column. A design that dropped one of them, or sent it to the wrong weight, would give products that are too low only for operands with several set middle bits. The exhaustive sweep and the all-ones pair 15 x 15 expose this.

Zero and unit operands show whether terms leak between columns. A design that mixed up an operand index would fail the swap check, which compares each pair with its mirror. Low-bit checks on r[0] and r[1] localise any error made before the first carry.

// File: rtl/cross_mul4.sv
module cross_mul4 #(
  parameter int W = 4,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] r
);

  function automatic logic [1:0] ha(input logic x, input logic y);
    ha = {x & y, x ^ y};
  endfunction

  function automatic logic [1:0] fa(input logic x, input logic y, input logic z);
    fa = {(x & y) | (z & (x ^ y)), x ^ y ^ z};
  endfunction

  logic [W-1:0][W-1:0] pp;

  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end

  logic k2;
  logic s2, k3a, k3b;
  logic s3a, s3b, k4a, k4b, k4c;
  logic s4a, s4b, k5a, k5b, k5c;
  logic s5a, s5b, k6a, k6b, k6c;
  logic s6, k7a, k7b;
  logic c8;

  assign r[0] = pp[0][0];

  assign {k2, r[1]}   = ha(pp[1][0], pp[0][1]);

  assign {k3a, s2}    = fa(pp[2][0], pp[1][1], pp[0][2]);
  assign {k3b, r[2]}  = ha(s2, k2);

  assign {k4a, s3a}   = fa(pp[3][0], pp[2][1], pp[1][2]);
  assign {k4b, s3b}   = fa(pp[0][3], s3a, k3a);
  assign {k4c, r[3]}  = ha(s3b, k3b);

  assign {k5a, s4a}   = fa(pp[3][1], pp[2][2], pp[1][3]);
  assign {k5b, s4b}   = fa(s4a, k4a, k4b);
  assign {k5c, r[4]}  = ha(s4b, k4c);

  assign {k6a, s5a}   = fa(pp[3][2], pp[2][3], k5a);
  assign {k6b, s5b}   = ha(s5a, k5b);
  assign {k6c, r[5]}  = ha(s5b, k5c);

  assign {k7a, s6}    = fa(pp[3][3], k6a, k6b);
  assign {k7b, r[6]}  = ha(s6, k6c);

  assign {c8, r[7]}   = ha(k7a, k7b);

endmodule

module cross_mul4_chk (
  input logic [3:0] a,
  input logic [3:0] b,
  input logic [7:0] r,
  input logic       spill
);
  always_comb begin
    AST_LSB_AND: assert (r[0] == (a[0] & b[0])); // R1
    AST_NO_SPILL: assert (spill == 1'b0); // R2
    AST_ZERO_OPERAND: assert (!((a == 4'd0) || (b == 4'd0)) || (r == 8'd0)); // R3
    AST_UNIT_A: assert (a != 4'd1 || r == {4'd0, b}); // R4
    AST_UNIT_B: assert (b != 4'd1 || r == {4'd0, a}); // R4
    AST_BOUND: assert (r <= 8'd225); // R6
    AST_COL1_XOR: assert (r[1] == ((a[1] & b[0]) ^ (a[0] & b[1]))); // R7
  end
endmodule

bind cross_mul4 cross_mul4_chk u_chk (.a(a), .b(b), .r(r), .spill(c8));

// File: tb/cross_mul4_test.sv
module cross_mul4_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] a, b;
  logic [7:0] r;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [7:0] seen [256];

  cross_mul4 uut (.a(a), .b(b), .r(r));

  function automatic logic [7:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] acc = 8'd0;
    for (int i = 0; i < 4; i++)
      if (x[i]) acc = acc + ({4'd0, y} << i);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s a=%0d b=%0d got=%0d expected=%0d", tag, a, b, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  task automatic full(input logic [3:0] x, input logic [3:0] y);
    drive(x, y);
    check("R2", r, ref_mul(x, y));
    check("R1", {7'd0, r[0]}, {7'd0, x[0] & y[0]});
    check("R7", {7'd0, r[1]}, {7'd0, (x[1] & y[0]) ^ (x[0] & y[1])});
    check("R6", {7'd0, r > 8'd225}, 8'd0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = 4'd0;
    b = 4'd0;
    #1;
    check("R3 initial", r, 8'd0);

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        full(x[3:0], y[3:0]);
        seen[{x[3:0], y[3:0]}] = r;
      end

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        compared++;
        if (seen[{x[3:0], y[3:0]}] !== seen[{y[3:0], x[3:0]}]) begin
          mismatched++;
          $display("FAIL R5 pair %0d,%0d got=%0d expected=%0d", x, y,
                   seen[{x[3:0], y[3:0]}], seen[{y[3:0], x[3:0]}]);
        end
      end

    for (int v = 0; v < 16; v++) begin
      drive(4'd0, v[3:0]);  check("R3", r, 8'd0);
      drive(v[3:0], 4'd0);  check("R3", r, 8'd0);
      drive(4'd1, v[3:0]);  check("R4", r, {4'd0, v[3:0]});
      drive(v[3:0], 4'd1);  check("R4", r, {4'd0, v[3:0]});
    end

    drive(4'hF, 4'hF);  check("R6", r, 8'hE1);
    drive(4'hC, 4'h6);  check("R2", r, 8'd72);
    drive(4'h7, 4'hE);  check("R2", r, 8'd98);

    for (int n = 0; n < 300; n++) begin
      logic [3:0] x, y;
      x = 4'($urandom);
      y = 4'($urandom);
      full(x, y);
      drive(y, x);
      check("R5", r, ref_mul(x, y));
    end

    finished = 1'b1;
    summary();
  end
endmodule